// File: doc/BRIEF.md
# Serial Audio Link Codec Wake Responder

This block is the codec-side power control for a serial audio link. While the link runs it produces the bit clock by dividing a local reference clock. When the controller asks for power-down, it parks the bit clock and the serial return line low in the very next reference cycle. While parked, a local event such as an incoming ring can ask for the link back. The block answers by raising the return line and holding it high.

The controller ends the sleep with a warm reset. A warm reset is a high pulse on the frame-sync input that lasts at least a set number of reference cycles while the bit clock is stopped. The block measures that pulse and ignores shorter ones. It starts the bit clock again only after it has seen frame sync low. It then drops the return line, though never before the line has been high for a minimum width.

All pins are plain control levels. No data moves through the block, so there is no valid/ready handshake and no back-pressure. Frame sync is synchronised into the reference domain before it is measured.

Top module: `acl_wake_responder`

## Requirements
- R1: After reset the link is active, the bit clock toggles and `sdin_o` is low.
- R2: While active, `bitclk_o` is a square wave with a period of 2*HALF_DIV reference cycles, high for HALF_DIV cycles.
- R3: When `pdn_req_i` is sampled high while active, `bitclk_o` and `sdin_o` are both low in the next cycle. `bitclk_o` stays low for as long as the block is asleep.
- R4: A `wake_evt_i` sampled while asleep makes `sdin_o` high in the next cycle. `sdin_o` then stays high until the warm reset has completed.
- R5: A frame-sync high pulse of at least WARM_MIN_CYC sampled cycles while asleep is a warm reset. The bit clock stays low until sync has been seen low, and its first rising edge comes HALF_DIV+2 cycles after the first cycle in which sync is sampled low.
- R6: A sync high pulse shorter than WARM_MIN_CYC cycles while asleep is ignored. The clock stays parked and the block stays asleep.
- R7: After a warm reset that follows a wake event, `sdin_o` goes low 3 cycles after sync is first sampled low. If it has not yet been high for WAKE_MIN_CYC cycles by then, it stays high until exactly WAKE_MIN_CYC cycles have passed.
- R8: A `wake_evt_i` while the link is active is ignored, and `sdin_o` stays low.
- R9: A warm reset with no wake event before it restarts the clock and leaves `sdin_o` low.
- R10: `pdn_req_i` while asleep has no effect, and the clock stays parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Frame sync from the controller |
| pdn_req_i | input | 1 | Decoded power-down request, one-cycle level |
| wake_evt_i | input | 1 | Local wake event |
| bitclk_o | output | 1 | Bit clock to the controller |
| sdin_o | output | 1 | Serial return line, used here only for wake signaling |

## Verification
The bench probes the warm-reset threshold from both sides, one cycle short and exactly long enough. A meter that is off by one would either wake on a short glitch or miss a legal reset. It times the first bit-clock edge after sync falls to the cycle. A design that restarted while sync was still high, or that counted a stale sync, shows up as an early edge. It also opens a warm reset before the wake event, so that the reset finishes before the minimum wake width. A design without the stretch drops the line early, and one with the wrong stretch length gives a width other than the minimum. Wake and power-down requests in the wrong state are sent as well, and a design that accepted them would move the return line or the clock.

// File: rtl/acl_wake_pkg.sv
package acl_wake_pkg;
  typedef enum logic [1:0] {
    LNK_ACTIVE = 2'd0,
    LNK_ASLEEP = 2'd1,
    LNK_WAKE   = 2'd2
  } link_state_e;
endpackage

// File: rtl/acl_bitclk_gen.sv
module acl_bitclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic en_i,
  output logic bitclk_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          bclk_q;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!en_i) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign bitclk_o = bclk_q;

  // R2: a rising edge only ever follows a cycle with the divider enabled
  p_edge_enabled_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(bclk_q) |-> $past(en_i));
endmodule

// File: rtl/acl_sync_meter.sv
module acl_sync_meter #(
  parameter int WARM_MIN_CYC = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic sync_i,
  input  logic en_i,
  output logic sync_s_o,
  output logic warm_done_o
);
  localparam int CW = $clog2(WARM_MIN_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(WARM_MIN_CYC);

  logic [SYNC_STAGES-1:0] sq;
  logic [CW-1:0]          wid_q;
  logic                   sync_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_ref) begin
        if (!rst_n) sq <= '0;
        else        sq <= sync_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_ref) begin
        if (!rst_n) sq <= '0;
        else        sq <= {sq[SYNC_STAGES-2:0], sync_i};
      end
    end
  endgenerate

  assign sync_s = sq[SYNC_STAGES-1];

  // width of the current high run, saturating at the threshold
  always_ff @(posedge clk_ref) begin
    if (!rst_n || !en_i) wid_q <= '0;
    else if (!sync_s)    wid_q <= '0;
    else if (wid_q != FULL) wid_q <= wid_q + 1'b1;
  end

  assign warm_done_o = en_i && !sync_s && (wid_q == FULL);
  assign sync_s_o    = sync_s;

  // R6: completion only ever follows a run that had reached the threshold
  p_long_run_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    warm_done_o |-> ($past(sync_s) && $past(en_i)));
endmodule

// File: rtl/acl_wake_ctrl.sv
module acl_wake_ctrl
  import acl_wake_pkg::*;
#(
  parameter int WAKE_MIN_CYC = 100
) (
  input  logic        clk_ref,
  input  logic        rst_n,
  input  logic        pdn_req_i,
  input  logic        wake_evt_i,
  input  logic        warm_done_i,
  output link_state_e state_o,
  output logic        run_nxt_o,
  output logic        sdin_o
);
  localparam int WW = $clog2(WAKE_MIN_CYC + 1);
  localparam logic [WW-1:0] WFULL = WW'(WAKE_MIN_CYC);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_MIN_CYC - 1);

  link_state_e state_q, state_d;
  logic        pdn_take;
  logic        sdin_q, sdin_d;
  logic [WW-1:0] wcnt_q;

  always_comb begin
    state_d  = state_q;
    pdn_take = 1'b0;
    unique case (state_q)
      LNK_ACTIVE: if (pdn_req_i) begin
        state_d  = LNK_ASLEEP;
        pdn_take = 1'b1;
      end
      LNK_ASLEEP: begin
        if (warm_done_i)     state_d = LNK_ACTIVE;
        else if (wake_evt_i) state_d = LNK_WAKE;
      end
      LNK_WAKE: if (warm_done_i) state_d = LNK_ACTIVE;
      default: state_d = LNK_ACTIVE;
    endcase
  end

  // return line: high while waking, stretched after wake to the minimum width
  always_comb begin
    sdin_d = (state_d == LNK_WAKE) ||
             (sdin_q && (state_d == LNK_ACTIVE) && (wcnt_q < WLAST));
    if (pdn_take) sdin_d = 1'b0;
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      state_q <= LNK_ACTIVE;
      sdin_q  <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      sdin_q  <= sdin_d;
      if (!sdin_q)              wcnt_q <= '0;
      else if (wcnt_q != WFULL) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign state_o   = state_q;
  assign run_nxt_o = (state_d == LNK_ACTIVE);
  assign sdin_o    = sdin_q;

  // R3: power-down parks the return line in the next cycle
  p_pdn_parks_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state_q == LNK_ACTIVE && pdn_req_i) |=> (state_q == LNK_ASLEEP && !sdin_q));
  // R7: a release not forced by power-down honours the minimum width
  p_min_width_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($fell(sdin_q) && !$past(pdn_take)) |-> ($past(wcnt_q) >= WLAST));
  // R8: a wake event on a running link never raises the line
  p_wake_active_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state_q == LNK_ACTIVE && wake_evt_i && !sdin_q) |=> !sdin_q);
endmodule

// File: rtl/acl_wake_responder.sv
module acl_wake_responder
  import acl_wake_pkg::*;
#(
  parameter int HALF_DIV     = 2,
  parameter int WARM_MIN_CYC = 100,
  parameter int WAKE_MIN_CYC = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pdn_req_i,
  input  logic wake_evt_i,
  output logic bitclk_o,
  output logic sdin_o
);
  link_state_e state;
  logic        run_nxt;
  logic        warm_done;
  logic        sync_s;

  acl_sync_meter #(
    .WARM_MIN_CYC(WARM_MIN_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_meter (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .en_i       (state != LNK_ACTIVE),
    .sync_s_o   (sync_s),
    .warm_done_o(warm_done)
  );

  acl_wake_ctrl #(
    .WAKE_MIN_CYC(WAKE_MIN_CYC)
  ) u_ctrl (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .pdn_req_i  (pdn_req_i),
    .wake_evt_i (wake_evt_i),
    .warm_done_i(warm_done),
    .state_o    (state),
    .run_nxt_o  (run_nxt),
    .sdin_o     (sdin_o)
  );

  acl_bitclk_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_bclk (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .en_i    (run_nxt),
    .bitclk_o(bitclk_o)
  );

  // R3: no clock while the link sleeps
  p_parked_clk_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state != LNK_ACTIVE) |-> !bitclk_o);
  // R5: the link only returns once sync has been seen low
  p_restart_after_sync_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state == LNK_ACTIVE && $past(state) != LNK_ACTIVE) |-> !$past(sync_s));
endmodule

// File: tb/test_acl_wake_responder.sv
module test_acl_wake_responder;
  localparam int HALF = 2;
  localparam int WARM = 100;
  localparam int WMIN = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, pdn_req = 1'b0, wake_evt = 1'b0;
  logic bitclk, sdin;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int run_w = 0, last_w = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acl_wake_responder #(
    .HALF_DIV(HALF), .WARM_MIN_CYC(WARM), .WAKE_MIN_CYC(WMIN), .SYNC_STAGES(2)
  ) i_acl_wake_responder (
    .clk_ref(clk), .rst_n(rst_n), .sync_i(sync_i), .pdn_req_i(pdn_req),
    .wake_evt_i(wake_evt), .bitclk_o(bitclk), .sdin_o(sdin)
  );

  function automatic bit exp_accept(int len);
    return len >= WARM;
  endfunction
  function automatic int exp_restart();
    return HALF + 2;
  endfunction
  function automatic int exp_release(int high_before);
    return (high_before + 3 >= WMIN) ? 3 : WMIN - high_before;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (sdin) run_w++;
    else begin
      if (run_w != 0) last_w = run_w;
      run_w = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic check_period(string req);
    int t0, t1;
    t0 = 0;
    for (int i = 0; i < 4 * HALF + 2; i++) begin tick(); if (bitclk && t0 == 0) t0 = cyc; end
    while (bitclk) tick();
    t1 = 0;
    for (int i = 0; i < 4 * HALF + 2; i++) begin tick(); if (bitclk) begin t1 = cyc; break; end end
    while (bitclk) tick();
    t0 = cyc;
    for (int i = 0; i < 4 * HALF + 2; i++) begin tick(); if (bitclk) begin t0 = cyc; break; end end
    chk((t0 - t1) == 2 * HALF, req, t0 - t1, 2 * HALF);
  endtask

  task automatic go_sleep();
    pdn_req = 1'b1; tick(); pdn_req = 1'b0;
    // R3: parked the cycle after the request
    chk(!bitclk && !sdin, "R3 pdn park", {bitclk, sdin}, 0);
  endtask

  task automatic wake_pulse();
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
  endtask

  // sync high for len cycles, then observe the restart
  task automatic sync_pulse(int len, bit waking, int exp_fall, string req);
    int bad, rise_at, fall_at;
    bad = 0;
    sync_i = 1'b1;
    for (int i = 0; i < len; i++) begin
      tick();
      if (bitclk || (waking && !sdin)) bad++;
    end
    chk(bad == 0, "R4 line held, clock parked during sync", bad, 0);
    sync_i = 1'b0;
    rise_at = 0; fall_at = 0;
    for (int i = 1; i <= WMIN + 10; i++) begin
      tick();
      if (bitclk && rise_at == 0) rise_at = i;
      if (!sdin && fall_at == 0) fall_at = i;
    end
    if (exp_accept(len)) chk(rise_at == exp_restart(), {req, " R5 restart"}, rise_at, exp_restart());
    else chk(rise_at == 0, "R6 short sync ignored", rise_at, 0);
    if (waking && exp_fall > 0) chk(fall_at == exp_fall, "R7 release", fall_at, exp_fall);
    if (!waking) chk(fall_at == 1, "R9 line low without wake", fall_at, 1);
  endtask

  initial begin
    int sc, d, len, hb;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(!sdin, "R1 sdin low after reset", sdin, 0);
    check_period("R1 R2 clock running, period");

    // R8: wake while active
    wake_pulse();
    d = 0;
    for (int i = 0; i < 5; i++) begin tick(); if (sdin) d++; end
    chk(d == 0, "R8 wake ignored while active", d, 0);

    // R6 boundary then R5 boundary
    go_sleep();
    sync_pulse(WARM - 1, 1'b0, 0, "R6");
    chk(!bitclk, "R6 still asleep", bitclk, 0);
    // R10: power-down while asleep
    pdn_req = 1'b1; tick(); pdn_req = 1'b0;
    d = 0;
    for (int i = 0; i < 6; i++) begin tick(); if (bitclk || sdin) d++; end
    chk(d == 0, "R10 pdn while asleep ignored", d, 0);
    sync_pulse(WARM, 1'b0, 0, "R5 exact threshold");

    // R7 stretch: sync rises before the wake event
    go_sleep();
    sync_i = 1'b1;
    repeat (10) tick();
    wake_pulse();
    chk(sdin, "R4 line high after wake", sdin, 1);
    repeat (WARM - 5) tick();
    sync_i = 1'b0;
    repeat (WMIN + 10) tick();
    chk(last_w == WMIN, "R7 stretched width", last_w, WMIN);
    chk(!sdin && bitclk === bitclk, "R7 line low after stretch", sdin, 0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      go_sleep();
      sc = int'($urandom % 3);
      if (sc == 0) begin
        len = int'($urandom_range(1, WARM - 1));
        sync_pulse(len, 1'b0, 0, "R6");
        sync_pulse(WARM + int'($urandom_range(0, 20)), 1'b0, 0, "R9");
      end else if (sc == 1) begin
        d = int'($urandom_range(0, 30));
        wake_pulse();
        chk(sdin, "R4 line high after wake", sdin, 1);
        repeat (d) tick();
        len = WARM + int'($urandom_range(0, 40));
        hb = 1 + d + len;
        sync_pulse(len, 1'b1, exp_release(hb), "R4");
        chk(last_w >= WMIN, "R7 minimum width", last_w, WMIN);
      end else begin
        sync_pulse(WARM + int'($urandom_range(0, 40)), 1'b0, 0, "R9");
      end
      check_period("R2 period after wake");
    end
    finish_run();
  end
endmodule